// File: doc/BRIEF.md
# Table Service Order Controller

This block is the control state machine of a table-side ordering terminal. A guest wakes the terminal and then moves through a menu, an item-detail view with an edit step, and a cart view where items can be removed. From the menu the order is sent. The controller then waits for payment, clears the cart storage and goes back to sleep. Staff assistance can be called from any of the interactive screens. The call suspends the current screen, and the screen comes back once staff acknowledge.

The controller does not hold the cart items or prices itself. It drives a small item memory through four strobes: write one item, search for an item to remove, read the whole cart out, and wipe the cart. Search, read and wipe keep their strobe high until the memory reports completion. The controller keeps only a count of stored items. Button presses and the staff acknowledge come in as single-cycle pulses and are registered once inside the block. The completion, edit-done and paid flags act on the state directly.

Top module: `tsc_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising edge, the controller enters sleep. The following are then all low: `item_count`, every memory strobe, `op_done` and `assist_on`. This applies at power-up and in the middle of a session.
- R2: `state_hot` has exactly one bit set. The bit index is the state code: 0 sleep, 1 menu, 2 item view, 3 edit, 4 cart view, 5 remove, 6 send, 7 cart read, 8 cart search, 9 cart wipe, 10 await payment, 11 assistance, 12 add item.
- R3: A request pulse that is high at rising edge k is captured at that edge and changes the state at edge k+1. `edit_done`, `mem_done` and `paid` change the state at the same edge at which they are sampled.
- R4: In the menu the request priority is assistance, then add, then view, then cart, then send. An add request enters the add state for one cycle with `mem_wr` high, then returns to the menu with `item_count` raised by one. When `item_count` equals `MAX_ITEMS`, an add request leaves both the state and the count unchanged.
- R5: From the menu, a view request enters item view. From item view, a modify request enters edit. In edit, `edit_done` returns to item view. A back request in item view or cart view returns to the menu.
- R6: In edit, an assistance request wins over `edit_done`. Assistance can be entered from menu, item view, edit and cart view. While in assistance, `assist_on` is high. An acknowledge returns the controller to the state it left.
- R7: In cart view, a remove request with `item_count` above zero goes to remove for one cycle and then to cart search. Cart search holds `mem_srch` high until `mem_done`, then returns to cart view with `item_count` lowered by one. A remove request with an empty cart is ignored.
- R8: A send request from the menu goes to send for one cycle and then to cart read. Cart read holds `mem_rd` high until `mem_done`, then goes to await payment.
- R9: Await payment holds until `paid`, then goes to cart wipe. Cart wipe holds `mem_wipe` high until `mem_done`, then goes to sleep with `item_count` at zero.
- R10: `op_done` is high for exactly the one cycle after the edge at which a search, read or wipe ends.
- R11: `mem_wr`, `mem_srch`, `mem_rd` and `mem_wipe` are each high only in their own state (add, cart search, cart read, cart wipe), and at most one of them is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wake_req | input | 1 | Wake pulse, leaves sleep |
| add_req | input | 1 | Add-item pulse from the menu |
| view_req | input | 1 | Open item view pulse |
| cart_req | input | 1 | Open cart view pulse |
| modify_req | input | 1 | Edit-item pulse from item view |
| remove_req | input | 1 | Remove-item pulse from cart view |
| back_req | input | 1 | Return-to-menu pulse |
| send_req | input | 1 | Send-order pulse from the menu |
| assist_req | input | 1 | Call-staff pulse |
| assist_ack | input | 1 | Staff acknowledge pulse |
| edit_done | input | 1 | Edit finished flag |
| mem_done | input | 1 | Item memory operation complete |
| paid | input | 1 | Payment received flag |
| state_hot | output | 13 | One-hot state decode, index = state code |
| mem_wr | output | 1 | Store one item |
| mem_rd | output | 1 | Read cart out |
| mem_srch | output | 1 | Search cart for item to remove |
| mem_wipe | output | 1 | Clear cart storage |
| assist_on | output | 1 | Assistance call active |
| op_done | output | 1 | One-cycle pulse after a memory operation ends |
| item_count | output | CNT_W | Items held in the cart |

## Verification
A corrupted state register shows up as a wrong `state_hot` bit at the next sample. The memory strobes follow that bit, so they go wrong in the same cycle. A wrong count or a wrong saved return state is harder to see. It only shows at the next point where the count or the return state is used: an add that should have been refused, a remove that should have been refused, an acknowledge that leads to the wrong screen, or an `item_count` other than zero after the wipe. The bench therefore follows full sessions with memory latencies from zero to two cycles. Along the way it checks every state step, every strobe and the count after each step.

// File: rtl/tsc_pkg.sv
// Shared definitions for the table service controller.
// Assumes: 13 states fit a 4-bit binary code; codes 13..15 are unused.
package tsc_pkg;
    localparam int NUM_ST = 13;
    localparam int ST_W   = 4;

    typedef enum logic [ST_W-1:0] {
        S_SLEEP   = 4'd0,
        S_ORDER   = 4'd1,
        S_VIEW    = 4'd2,
        S_MODIFY  = 4'd3,
        S_CART    = 4'd4,
        S_REMOVE  = 4'd5,
        S_SEND    = 4'd6,
        S_READ    = 4'd7,
        S_SEARCH  = 4'd8,
        S_WIPE    = 4'd9,
        S_PAYWAIT = 4'd10,
        S_ASSIST  = 4'd11,
        S_ADD     = 4'd12
    } st_e;

    // Registered user request pulses
    typedef struct packed {
        logic wake;
        logic add;
        logic view;
        logic cart;
        logic modify;
        logic remove;
        logic back;
        logic send;
        logic assist;
        logic ack;
    } req_t;

    localparam int REQ_W = $bits(req_t);
endpackage

// File: rtl/tsc_en_reg.sv
// Positive-edge register with synchronous active-low reset to zero and a
// write enable; holds its value while the enable is low.
// Assumes: reset takes priority over the enable.
module tsc_en_reg #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Load on enable, clear on reset, otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= d;
    end
endmodule

// File: rtl/tsc_next_state.sv
// Next-state logic of the ordering controller, plus capture of the state
// an assistance call interrupts.
// Assumes: request inputs are already registered; flags are live.
module tsc_next_state
    import tsc_pkg::*;
(
    input  logic [ST_W-1:0] cur,
    input  logic [ST_W-1:0] ret,
    input  req_t            r,
    input  logic            edit_done,
    input  logic            mem_done,
    input  logic            paid,
    input  logic            full,
    input  logic            empty,
    output logic [ST_W-1:0] nxt,
    output logic            ret_en
);
    // State transition table; unused codes fall back to sleep
    always_comb begin
        nxt = cur;
        case (cur)
            S_SLEEP:   if (r.wake) nxt = S_ORDER;
            S_ORDER: begin
                if (r.assist)            nxt = S_ASSIST;
                else if (r.add && !full) nxt = S_ADD;
                else if (r.view)         nxt = S_VIEW;
                else if (r.cart)         nxt = S_CART;
                else if (r.send)         nxt = S_SEND;
            end
            S_ADD:     nxt = S_ORDER;
            S_VIEW: begin
                if (r.assist)      nxt = S_ASSIST;
                else if (r.modify) nxt = S_MODIFY;
                else if (r.back)   nxt = S_ORDER;
            end
            S_MODIFY: begin
                if (r.assist)         nxt = S_ASSIST;
                else if (edit_done)   nxt = S_VIEW;
            end
            S_CART: begin
                if (r.assist)                 nxt = S_ASSIST;
                else if (r.remove && !empty)  nxt = S_REMOVE;
                else if (r.back)              nxt = S_ORDER;
            end
            S_REMOVE:  nxt = S_SEARCH;
            S_SEARCH:  if (mem_done) nxt = S_CART;
            S_SEND:    nxt = S_READ;
            S_READ:    if (mem_done) nxt = S_PAYWAIT;
            S_PAYWAIT: if (paid) nxt = S_WIPE;
            S_WIPE:    if (mem_done) nxt = S_SLEEP;
            S_ASSIST:  if (r.ack) nxt = ret;
            default:   nxt = S_SLEEP;
        endcase
    end

    // Save the interrupted state on entry to assistance
    always_comb ret_en = (nxt == S_ASSIST) && (cur != S_ASSIST);
endmodule

// File: rtl/tsc_out_dec.sv
// Output decode: one-hot state vector and memory control strobes.
// Assumes: state codes 0..NUM_ST-1 map to bit indices of the vector.
module tsc_out_dec
    import tsc_pkg::*;
(
    input  logic [ST_W-1:0]   cur,
    output logic [NUM_ST-1:0] state_hot,
    output logic              mem_wr,
    output logic              mem_rd,
    output logic              mem_srch,
    output logic              mem_wipe,
    output logic              assist_on
);
    // One comparator per state code
    for (genvar i = 0; i < NUM_ST; i++) begin : g_hot
        assign state_hot[i] = (cur == ST_W'(i));
    end

    // Memory strobes and assistance indicator
    always_comb begin
        mem_wr    = state_hot[S_ADD];
        mem_rd    = state_hot[S_READ];
        mem_srch  = state_hot[S_SEARCH];
        mem_wipe  = state_hot[S_WIPE];
        assist_on = state_hot[S_ASSIST];
    end
endmodule

// File: rtl/tsc_ctrl.sv
// Top of the table service order controller: registers request pulses,
// holds the binary state, the return state and the item count, and
// raises a one-cycle done pulse after each memory operation.
// Assumes: requests are single-cycle pulses; mem_done is only meaningful
// while a search, read or wipe strobe is high.
module tsc_ctrl
    import tsc_pkg::*;
#(
    parameter int MAX_ITEMS = 8,
    parameter int CNT_W     = $clog2(MAX_ITEMS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wake_req,
    input  logic              add_req,
    input  logic              view_req,
    input  logic              cart_req,
    input  logic              modify_req,
    input  logic              remove_req,
    input  logic              back_req,
    input  logic              send_req,
    input  logic              assist_req,
    input  logic              assist_ack,
    input  logic              edit_done,
    input  logic              mem_done,
    input  logic              paid,
    output logic [NUM_ST-1:0] state_hot,
    output logic              mem_wr,
    output logic              mem_rd,
    output logic              mem_srch,
    output logic              mem_wipe,
    output logic              assist_on,
    output logic              op_done,
    output logic [CNT_W-1:0]  item_count
);
    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_ITEMS);

    req_t            req_d, req_q;
    logic [ST_W-1:0] cur, nxt, ret;
    logic            ret_en, st_en;
    logic            full, empty, mem_end;
    logic            cnt_en;
    logic [CNT_W-1:0] cnt_d;

    // Gather request pulses for the input register
    always_comb begin
        req_d.wake   = wake_req;
        req_d.add    = add_req;
        req_d.view   = view_req;
        req_d.cart   = cart_req;
        req_d.modify = modify_req;
        req_d.remove = remove_req;
        req_d.back   = back_req;
        req_d.send   = send_req;
        req_d.assist = assist_req;
        req_d.ack    = assist_ack;
    end

    tsc_en_reg #(.W(REQ_W)) u_req_reg (
        .clk(clk), .rst_n(rst_n), .en(1'b1), .d(req_d), .q(req_q)
    );

    // Count status feeding the transition logic
    always_comb begin
        full  = (item_count == MAX_C);
        empty = (item_count == '0);
    end

    tsc_next_state u_nsl (
        .cur(cur), .ret(ret), .r(req_q),
        .edit_done(edit_done), .mem_done(mem_done), .paid(paid),
        .full(full), .empty(empty), .nxt(nxt), .ret_en(ret_en)
    );

    // Write the state register only when it changes
    always_comb st_en = (nxt != cur);

    tsc_en_reg #(.W(ST_W)) u_state_reg (
        .clk(clk), .rst_n(rst_n), .en(st_en), .d(nxt), .q(cur)
    );

    tsc_en_reg #(.W(ST_W)) u_ret_reg (
        .clk(clk), .rst_n(rst_n), .en(ret_en), .d(cur), .q(ret)
    );

    // Item count update: add, completed search, completed wipe
    always_comb begin
        mem_end = mem_done && ((cur == S_READ) || (cur == S_SEARCH) || (cur == S_WIPE));
        cnt_en  = (cur == S_ADD) || (mem_done && ((cur == S_SEARCH) || (cur == S_WIPE)));
        if (cur == S_WIPE)     cnt_d = '0;
        else if (cur == S_ADD) cnt_d = item_count + 1'b1;
        else                   cnt_d = item_count - 1'b1;
    end

    tsc_en_reg #(.W(CNT_W)) u_cnt_reg (
        .clk(clk), .rst_n(rst_n), .en(cnt_en), .d(cnt_d), .q(item_count)
    );

    tsc_en_reg #(.W(1)) u_done_reg (
        .clk(clk), .rst_n(rst_n), .en(1'b1), .d(mem_end), .q(op_done)
    );

    tsc_out_dec u_dec (
        .cur(cur), .state_hot(state_hot),
        .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_srch(mem_srch),
        .mem_wipe(mem_wipe), .assist_on(assist_on)
    );
endmodule

// File: rtl/tsc_ctrl_chk.sv
// Property checker for tsc_ctrl, attached with bind below.
// Assumes: state_hot bit indices follow the state codes of tsc_pkg.
module tsc_ctrl_chk
    import tsc_pkg::*;
#(
    parameter int MAX_ITEMS = 8,
    parameter int CNT_W     = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_ST-1:0] state_hot,
    input logic              mem_wr,
    input logic              mem_rd,
    input logic              mem_srch,
    input logic              mem_wipe,
    input logic              mem_done,
    input logic              paid,
    input logic              op_done,
    input logic              assist_q,
    input logic [CNT_W-1:0]  item_count
);
    // R2: exactly one state decode active
    a_r2_one_state: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state_hot) == 1);

    // R11: memory strobes never overlap
    a_r11_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_wr, mem_rd, mem_srch, mem_wipe}));

    // R4: count never exceeds capacity
    a_r4_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
        item_count <= CNT_W'(MAX_ITEMS));

    // R8: cart read holds until the memory completes
    a_r8_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        state_hot[S_READ] && !mem_done |=> state_hot[S_READ]);

    // R9: await payment holds without paid
    a_r9_pay_hold: assert property (@(posedge clk) disable iff (!rst_n)
        state_hot[S_PAYWAIT] && !paid |=> state_hot[S_PAYWAIT]);

    // R9: finished wipe lands in sleep with an empty cart
    a_r9_wipe_end: assert property (@(posedge clk) disable iff (!rst_n)
        state_hot[S_WIPE] && mem_done |=> state_hot[S_SLEEP] && item_count == '0);

    // R6: assistance wins over edit completion
    a_r6_assist_wins: assert property (@(posedge clk) disable iff (!rst_n)
        state_hot[S_MODIFY] && assist_q |=> state_hot[S_ASSIST]);

    // R10: done pulse lasts one cycle and follows a completion
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> !op_done);
    a_r10_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(op_done) |-> $past(mem_done) && $past(mem_rd || mem_srch || mem_wipe));
endmodule

bind tsc_ctrl tsc_ctrl_chk #(.MAX_ITEMS(MAX_ITEMS), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .state_hot(state_hot),
    .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_srch(mem_srch), .mem_wipe(mem_wipe),
    .mem_done(mem_done), .paid(paid), .op_done(op_done),
    .assist_q(req_q.assist), .item_count(item_count)
);

// File: tb/tsc_ctrl_tb.sv
// Self-checking bench: full sessions with 1..3 items and memory latency
// 0..2, plus capacity, empty-cart and reset boundaries.
module tsc_ctrl_tb;
    localparam int MAXI = 8;
    localparam int CW   = $clog2(MAXI + 1);

    localparam int SLP = 0, ORD = 1, VIW = 2, MOD = 3, CRT = 4, REM = 5,
                   SND = 6, RD = 7, SRC = 8, WIP = 9, PAY = 10, AST = 11, ADD = 12;

    logic clk = 0, rst_n = 0;
    logic wake_req = 0, add_req = 0, view_req = 0, cart_req = 0, modify_req = 0;
    logic remove_req = 0, back_req = 0, send_req = 0, assist_req = 0, assist_ack = 0;
    logic edit_done = 0, mem_done = 0, paid = 0;
    logic [12:0] state_hot;
    logic mem_wr, mem_rd, mem_srch, mem_wipe, assist_on, op_done;
    logic [CW-1:0] item_count;

    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    tsc_ctrl #(.MAX_ITEMS(MAXI)) u_dut (.*);

    task automatic tick; @(negedge clk); endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int hot_idx();
        for (int i = 0; i < 13; i++) if (state_hot[i]) return i;
        return -1;
    endfunction

    task automatic exp_st(input int s, input string req);
        chk(state_hot == (13'd1 << s), req, hot_idx(), s);
    endtask

    task automatic set_req(input int id, input logic v);
        case (id)
            0: wake_req = v;   1: add_req = v;    2: view_req = v;
            3: cart_req = v;   4: modify_req = v; 5: remove_req = v;
            6: back_req = v;   7: send_req = v;   8: assist_req = v;
            default: assist_ack = v;
        endcase
    endtask

    // pulse a request; state reflects it two edges later
    task automatic press(input int id);
        set_req(id, 1); tick; set_req(id, 0); tick;
    endtask

    // wait lat cycles in a memory state, then complete it
    task automatic finish_mem(input int st, input int lat, input string req);
        for (int k = 0; k < lat; k++) begin
            tick; exp_st(st, req);
        end
        mem_done = 1; tick; mem_done = 0;
        chk(op_done == 1, "R10", op_done, 1);
    endtask

    task automatic session(input int n, input int lat);
        press(0); exp_st(ORD, "R3");
        for (int i = 0; i < n; i++) begin
            press(1); exp_st(ADD, "R4");
            chk(mem_wr == 1, "R11", mem_wr, 1);
            tick; exp_st(ORD, "R4");
            chk(int'(item_count) == i + 1, "R4", item_count, i + 1);
        end
        press(2); exp_st(VIW, "R5");
        press(4); exp_st(MOD, "R5");
        // assist and edit_done reach the state at the same edge
        assist_req = 1; tick; assist_req = 0; edit_done = 1; tick; edit_done = 0;
        exp_st(AST, "R6");
        chk(assist_on == 1, "R6", assist_on, 1);
        press(9); exp_st(MOD, "R6");
        chk(assist_on == 0, "R6", assist_on, 0);
        edit_done = 1; tick; edit_done = 0; exp_st(VIW, "R5");
        press(6); exp_st(ORD, "R5");
        press(3); exp_st(CRT, "R4");
        press(5); exp_st(REM, "R7");
        tick; exp_st(SRC, "R7");
        chk(mem_srch == 1 && mem_rd == 0, "R11", mem_srch, 1);
        finish_mem(SRC, lat, "R7");
        exp_st(CRT, "R7");
        chk(int'(item_count) == n - 1, "R7", item_count, n - 1);
        tick; chk(op_done == 0, "R10", op_done, 0);
        press(6); exp_st(ORD, "R5");
        press(7); exp_st(SND, "R8");
        tick; exp_st(RD, "R8");
        chk(mem_rd == 1, "R11", mem_rd, 1);
        finish_mem(RD, lat, "R8");
        exp_st(PAY, "R8");
        for (int k = 0; k < 3; k++) begin
            tick; exp_st(PAY, "R9");
        end
        paid = 1; tick; paid = 0; exp_st(WIP, "R9");
        chk(mem_wipe == 1, "R11", mem_wipe, 1);
        finish_mem(WIP, lat, "R9");
        exp_st(SLP, "R9");
        chk(item_count == 0, "R9", item_count, 0);
        tick; chk(op_done == 0, "R10", op_done, 0);
    endtask

    initial begin
        tick; tick;
        exp_st(SLP, "R1");
        chk({mem_wr, mem_rd, mem_srch, mem_wipe, op_done, assist_on} == 0, "R1", 1, 0);
        chk(item_count == 0, "R1", item_count, 0);
        rst_n = 1; tick;

        // R3: request latency is two edges
        wake_req = 1; tick; wake_req = 0;
        exp_st(SLP, "R3");
        tick; exp_st(ORD, "R3");
        // R4: assistance beats add in the menu
        assist_req = 1; add_req = 1; tick; assist_req = 0; add_req = 0; tick;
        exp_st(AST, "R4");
        press(9); exp_st(ORD, "R6");
        chk(item_count == 0, "R4", item_count, 0);
        // R1: reset mid-session
        rst_n = 0; tick; exp_st(SLP, "R1"); rst_n = 1; tick;

        for (int n = 1; n <= 3; n++) session(n, n - 1);

        // R7: remove with empty cart ignored
        press(0); press(3); exp_st(CRT, "R4");
        press(5); exp_st(CRT, "R7");
        chk(item_count == 0, "R7", item_count, 0);
        tick; exp_st(CRT, "R7");
        press(6); exp_st(ORD, "R5");

        // R4: fill to capacity, extra add ignored
        for (int i = 0; i < MAXI; i++) begin
            press(1); tick;
        end
        chk(int'(item_count) == MAXI, "R4", item_count, MAXI);
        press(1); exp_st(ORD, "R4");
        chk(mem_wr == 0, "R4", mem_wr, 0);
        tick; exp_st(ORD, "R4");
        chk(int'(item_count) == MAXI, "R4", item_count, MAXI);

        // drain: send, pay, wipe
        press(7); tick; finish_mem(RD, 1, "R8"); exp_st(PAY, "R8");
        paid = 1; tick; paid = 0; finish_mem(WIP, 0, "R9");
        exp_st(SLP, "R9");
        chk(item_count == 0, "R9", item_count, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule